// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a precision time-of-day for three independent clock domains. Each domain holds a 48-bit seconds count, a 30-bit nanoseconds count and a 59-bit sub-nanosecond accumulator. On every core clock cycle an enabled domain advances by its own 64-bit period value, given in units of 2^-59 ns. When the nanoseconds reach one billion they fold back into the seconds in the same cycle.

Software reaches the domains through two paths. A small register write port holds the per-domain period words, the domain run enables and a per-domain gate that freezes the period in use while the two halves of a new period are being written. A shared access port holds shadow seconds and nanoseconds and takes a 3-bit command with a domain select. The commands capture the live time into the shadow, load the shadow into a domain, or step a domain by a signed nanosecond amount. A step that lands just below a second boundary is held as a small negative nanoseconds code rather than borrowing from the seconds.

Top module: `ptp_tod_top`

## Requirements
- R1: After reset every domain reads 0 s / 0 ns, the shadow reads 0 s / 0 ns and every domain is stopped.
- R2: An enabled domain advances every cycle by its period: bits [63:59] are whole nanoseconds and bits [58:0] a fraction whose carry adds one more nanosecond (0x4000000000000000 is 8 ns per cycle, 0x0400000000000000 is 1 ns every two cycles).
- R3: A domain whose run bit is clear keeps its time, and running one domain leaves the others unchanged; the run bits sit at register address 6, bit d for domain d.
- R4: When nanoseconds would reach 1,000,000,000 they are reduced by 10^9 and seconds rise by one in the same cycle.
- R5: The period of domain d is written at address 2d (bits [31:0]) and 2d+1 (bits [63:32]); while gate bit d at address 7 is set the old period stays in use, and the new one applies from the second cycle after the gate is cleared.
- R6: Command codes are 0 idle, 1 load, 2 save, 3 clock, 4 delta, 5 tod; codes 3, 5, 6, 7 and any domain select of 3 or above change neither time nor shadow; a command acts on the clock edge after the one that takes it, after which the port is idle again.
- R7: Save copies the selected domain's seconds and nanoseconds into the shadow, readable after the acting edge.
- R8: Load copies the shadow into the selected domain only when the command issued before it was idle; otherwise it is ignored.
- R9: Delta adds the shadow nanoseconds, read as a signed 30-bit value, to the selected domain, carrying into or borrowing from the seconds as needed.
- R10: A delta result from -16 to -1 ns is kept as nanoseconds codes 0x3FFFFFF0 to 0x3FFFFFFF with seconds unchanged, and counting carries it up through zero.
- R11: The shadow is written at address 8 (seconds [47:32] from data [15:0]), 9 (seconds [31:0]) and 10 (nanoseconds from data [29:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| cmd_we_i | input | 1 | Access-port command strobe |
| cmd_code_i | input | 3 | Command code |
| cmd_dom_i | input | 2 | Domain the command acts on |
| shd_sec_o | output | 48 | Shadow seconds |
| shd_ns_o | output | 30 | Shadow nanoseconds |
| tod_sec_o | output | 144 | Seconds of all domains, domain d at [48d+47:48d] |
| tod_ns_o | output | 90 | Nanoseconds of all domains, domain d at [30d+29:30d] |

## Verification
On every cycle the assertions hold that a stopped, untouched domain keeps its time, that the period in use does not move while its gate is set, that nanoseconds stay below one billion or inside the negative band, that seconds only step by one outside a load, and that the port falls back to idle with at most one domain strobed. The arithmetic itself can only be shown by the bench scenarios: exact counts after a fixed number of cycles, fractional carries, the load acceptance rule, save contents, and delta results across carry, borrow and the negative band.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int unsigned PER_W      = 64;
    localparam int unsigned FRAC_W     = 59;
    localparam int unsigned SEC_W      = 48;
    localparam int unsigned NS_W       = 30;
    localparam int unsigned NS_PER_SEC = 1_000_000_000;
    localparam logic [NS_W-1:0]  NEG_BAND_LO    = 30'h3FFF_FFF0;
    localparam logic [PER_W-1:0] NOMINAL_PERIOD = 64'h1FF0_0000_0000_0000;

    localparam logic [2:0] CMD_IDLE  = 3'd0;
    localparam logic [2:0] CMD_LOAD  = 3'd1;
    localparam logic [2:0] CMD_SAVE  = 3'd2;
    localparam logic [2:0] CMD_CLOCK = 3'd3;
    localparam logic [2:0] CMD_DELTA = 3'd4;
    localparam logic [2:0] CMD_TOD   = 3'd5;
endpackage

// File: rtl/ptp_tod_dom.sv
module ptp_tod_dom
    import ptp_tod_pkg::*;
#(
    parameter int unsigned SW = SEC_W,
    parameter int unsigned NW = NS_W,
    parameter int unsigned PW = PER_W,
    parameter int unsigned FW = FRAC_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [PW-1:0] period_i,
    input  logic          load_i,
    input  logic [SW-1:0] load_sec_i,
    input  logic [NW-1:0] load_ns_i,
    input  logic          step_i,
    input  logic [NW-1:0] step_ns_i,
    output logic [SW-1:0] sec_o,
    output logic [NW-1:0] ns_o
);
    localparam int unsigned IW = PW - FW;
    localparam int unsigned XW = NW + 3;
    localparam logic signed [XW-1:0] BILLION   = XW'(NS_PER_SEC);
    localparam logic signed [XW-1:0] NEG_FLOOR = XW'(-16);

    typedef struct packed {
        logic [SW-1:0] sec;
        logic [NW-1:0] ns;
        logic [FW-1:0] frac;
    } dom_state_t;

    dom_state_t s_q, s_d;
    logic [FW:0]           frac_sum;
    logic [IW:0]           inc_ns;
    logic                  neg_band;
    logic signed [XW-1:0]  ns_cur, ns_step, ns_inc, ns_sum;

    always_comb begin
        s_d      = s_q;
        frac_sum = {1'b0, s_q.frac} + {1'b0, period_i[FW-1:0]};
        inc_ns   = '0;
        if (run_i) begin
            inc_ns    = {1'b0, period_i[PW-1:FW]} + {{IW{1'b0}}, frac_sum[FW]};
            s_d.frac  = frac_sum[FW-1:0];
        end
        // a nanoseconds code in the top band stands for a small negative value
        neg_band = (s_q.ns >= NEG_BAND_LO);
        ns_cur   = {{3{neg_band}}, s_q.ns};
        ns_step  = step_i ? {{3{step_ns_i[NW-1]}}, step_ns_i} : '0;
        ns_inc   = {{(XW-IW-1){1'b0}}, inc_ns};
        ns_sum   = ns_cur + ns_step + ns_inc;
        if (ns_sum >= BILLION) begin
            s_d.ns  = NW'(ns_sum - BILLION);
            s_d.sec = s_q.sec + SW'(1);
        end else if (ns_sum < NEG_FLOOR) begin
            s_d.ns  = NW'(ns_sum + BILLION);
            s_d.sec = s_q.sec - SW'(1);
        end else begin
            s_d.ns  = NW'(ns_sum);
        end
        if (load_i) begin
            s_d.sec = load_sec_i;
            s_d.ns  = load_ns_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sec_o = s_q.sec;
    assign ns_o  = s_q.ns;
endmodule

// File: rtl/ptp_tod_cfg.sv
module ptp_tod_cfg
    import ptp_tod_pkg::*;
#(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned AW      = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned PW      = PER_W,
    parameter logic [PW-1:0] RESET_PERIOD = NOMINAL_PERIOD
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [NUM_DOM-1:0][PW-1:0]  period_o,
    output logic [NUM_DOM-1:0]          run_o,
    output logic [NUM_DOM-1:0]          gate_o
);
    localparam int unsigned ADDR_RUN  = 2 * NUM_DOM;
    localparam int unsigned ADDR_GATE = ADDR_RUN + 1;

    typedef struct packed {
        logic [NUM_DOM-1:0][PW-1:0] stage;
        logic [NUM_DOM-1:0][PW-1:0] act;
        logic [NUM_DOM-1:0]         run;
        logic [NUM_DOM-1:0]         gate;
    } cfg_state_t;

    cfg_state_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (!c_q.gate[d]) c_d.act[d] = c_q.stage[d];
            if (we_i && addr_i == AW'(2 * d))     c_d.stage[d][DW-1:0]  = wdata_i;
            if (we_i && addr_i == AW'(2 * d + 1)) c_d.stage[d][PW-1:DW] = wdata_i;
        end
        if (we_i && addr_i == AW'(ADDR_RUN))  c_d.run  = wdata_i[NUM_DOM-1:0];
        if (we_i && addr_i == AW'(ADDR_GATE)) c_d.gate = wdata_i[NUM_DOM-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int d = 0; d < NUM_DOM; d++) begin
                c_q.stage[d] <= RESET_PERIOD;
                c_q.act[d]   <= RESET_PERIOD;
            end
            c_q.run  <= '0;
            c_q.gate <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign period_o = c_q.act;
    assign run_o    = c_q.run;
    assign gate_o   = c_q.gate;
endmodule

// File: rtl/ptp_tod_acc.sv
module ptp_tod_acc
    import ptp_tod_pkg::*;
#(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned DOM_W   = 2,
    parameter int unsigned AW      = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned SW      = SEC_W,
    parameter int unsigned NW      = NS_W
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        reg_we_i,
    input  logic [AW-1:0]               reg_addr_i,
    input  logic [DW-1:0]               reg_wdata_i,
    input  logic                        cmd_we_i,
    input  logic [2:0]                  cmd_code_i,
    input  logic [DOM_W-1:0]            cmd_dom_i,
    input  logic [NUM_DOM-1:0][SW-1:0]  tod_sec_i,
    input  logic [NUM_DOM-1:0][NW-1:0]  tod_ns_i,
    output logic [NUM_DOM-1:0]          load_o,
    output logic [NUM_DOM-1:0]          step_o,
    output logic [SW-1:0]               shd_sec_o,
    output logic [NW-1:0]               shd_ns_o
);
    localparam int unsigned ADDR_SHI = 2 * NUM_DOM + 2;
    localparam int unsigned ADDR_SLO = ADDR_SHI + 1;
    localparam int unsigned ADDR_SNS = ADDR_SHI + 2;

    typedef struct packed {
        logic [2:0]       code;
        logic [DOM_W-1:0] dom;
        logic             ok;
        logic [2:0]       last;
        logic [SW-1:0]    shd_sec;
        logic [NW-1:0]    shd_ns;
    } acc_state_t;

    acc_state_t a_q, a_d;

    always_comb begin
        a_d      = a_q;
        a_d.code = CMD_IDLE;
        a_d.ok   = 1'b0;
        load_o   = '0;
        step_o   = '0;
        if (cmd_we_i) begin
            a_d.code = cmd_code_i;
            a_d.dom  = cmd_dom_i;
            a_d.ok   = (a_q.last == CMD_IDLE);
            a_d.last = cmd_code_i;
        end
        if (reg_we_i) begin
            if (reg_addr_i == AW'(ADDR_SHI)) a_d.shd_sec[SW-1:DW] = reg_wdata_i[SW-DW-1:0];
            if (reg_addr_i == AW'(ADDR_SLO)) a_d.shd_sec[DW-1:0]  = reg_wdata_i;
            if (reg_addr_i == AW'(ADDR_SNS)) a_d.shd_ns           = reg_wdata_i[NW-1:0];
        end
        for (int d = 0; d < NUM_DOM; d++) begin
            if (a_q.dom == DOM_W'(d)) begin
                load_o[d] = (a_q.code == CMD_LOAD) && a_q.ok;
                step_o[d] = (a_q.code == CMD_DELTA);
                if (a_q.code == CMD_SAVE) begin
                    a_d.shd_sec = tod_sec_i[d];
                    a_d.shd_ns  = tod_ns_i[d];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_q      <= '0;
            a_q.code <= CMD_IDLE;
            a_q.last <= CMD_IDLE;
        end else begin
            a_q <= a_d;
        end
    end

    assign shd_sec_o = a_q.shd_sec;
    assign shd_ns_o  = a_q.shd_ns;
endmodule

// File: rtl/ptp_tod_top.sv
module ptp_tod_top
    import ptp_tod_pkg::*;
#(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned DOM_W   = $clog2(NUM_DOM),
    parameter int unsigned AW      = 4,
    parameter int unsigned DW      = 32,
    parameter int unsigned SW      = SEC_W,
    parameter int unsigned NW      = NS_W,
    parameter int unsigned PW      = PER_W,
    parameter logic [PW-1:0] RESET_PERIOD = NOMINAL_PERIOD
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    reg_we_i,
    input  logic [AW-1:0]           reg_addr_i,
    input  logic [DW-1:0]           reg_wdata_i,
    input  logic                    cmd_we_i,
    input  logic [2:0]              cmd_code_i,
    input  logic [DOM_W-1:0]        cmd_dom_i,
    output logic [SW-1:0]           shd_sec_o,
    output logic [NW-1:0]           shd_ns_o,
    output logic [NUM_DOM*SW-1:0]   tod_sec_o,
    output logic [NUM_DOM*NW-1:0]   tod_ns_o
);
    logic [NUM_DOM-1:0][PW-1:0] dom_period;
    logic [NUM_DOM-1:0]         dom_run, dom_gate, dom_load, dom_step;
    logic [NUM_DOM-1:0][SW-1:0] dom_sec;
    logic [NUM_DOM-1:0][NW-1:0] dom_ns;

    ptp_tod_cfg #(
        .NUM_DOM(NUM_DOM), .AW(AW), .DW(DW), .PW(PW), .RESET_PERIOD(RESET_PERIOD)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .period_o (dom_period),
        .run_o    (dom_run),
        .gate_o   (dom_gate)
    );

    ptp_tod_acc #(
        .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .AW(AW), .DW(DW), .SW(SW), .NW(NW)
    ) u_acc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .cmd_we_i    (cmd_we_i),
        .cmd_code_i  (cmd_code_i),
        .cmd_dom_i   (cmd_dom_i),
        .tod_sec_i   (dom_sec),
        .tod_ns_i    (dom_ns),
        .load_o      (dom_load),
        .step_o      (dom_step),
        .shd_sec_o   (shd_sec_o),
        .shd_ns_o    (shd_ns_o)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        ptp_tod_dom #(.SW(SW), .NW(NW), .PW(PW), .FW(FRAC_W)) u_dom (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .run_i      (dom_run[d]),
            .period_i   (dom_period[d]),
            .load_i     (dom_load[d]),
            .load_sec_i (shd_sec_o),
            .load_ns_i  (shd_ns_o),
            .step_i     (dom_step[d]),
            .step_ns_i  (shd_ns_o),
            .sec_o      (dom_sec[d]),
            .ns_o       (dom_ns[d])
        );
    end

    assign tod_sec_o = dom_sec;
    assign tod_ns_o  = dom_ns;
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
    import ptp_tod_pkg::*;
#(
    parameter int unsigned NUM_DOM = 3,
    parameter int unsigned SW      = SEC_W,
    parameter int unsigned NW      = NS_W,
    parameter int unsigned PW      = PER_W
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        cmd_we_i,
    input logic [NUM_DOM-1:0]          dom_run,
    input logic [NUM_DOM-1:0]          dom_gate,
    input logic [NUM_DOM-1:0]          dom_load,
    input logic [NUM_DOM-1:0]          dom_step,
    input logic [NUM_DOM-1:0][PW-1:0]  dom_period,
    input logic [NUM_DOM-1:0][SW-1:0]  dom_sec,
    input logic [NUM_DOM-1:0][NW-1:0]  dom_ns
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        // R3
        stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!dom_run[d] && !dom_load[d] && !dom_step[d]) |=>
            ($stable(dom_sec[d]) && $stable(dom_ns[d])));

        // R5
        gated_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            dom_gate[d] |=> $stable(dom_period[d]));

        // R10
        ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dom_ns[d] < NW'(NS_PER_SEC)) || (dom_ns[d] >= NEG_BAND_LO));

        // R4
        sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !dom_load[d] |=> ((dom_sec[d] == $past(dom_sec[d])) ||
                              (dom_sec[d] == $past(dom_sec[d]) + SW'(1)) ||
                              (dom_sec[d] == $past(dom_sec[d]) - SW'(1))));
    end

    // R6
    port_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_we_i |=> ((dom_load == '0) && (dom_step == '0)));

    // R6
    single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dom_load | dom_step));
endmodule

bind ptp_tod_top ptp_tod_chk #(
    .NUM_DOM(NUM_DOM), .SW(SW), .NW(NW), .PW(PW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we_i),
    .dom_run    (dom_run),
    .dom_gate   (dom_gate),
    .dom_load   (dom_load),
    .dom_step   (dom_step),
    .dom_period (dom_period),
    .dom_sec    (dom_sec),
    .dom_ns     (dom_ns)
);

// File: tb/ptp_tod_top_bench.sv
module ptp_tod_top_bench;
    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          cmd_we = 1'b0;
    logic [2:0]    cmd_code = '0;
    logic [1:0]    cmd_dom = '0;
    logic [47:0]   shd_sec;
    logic [29:0]   shd_ns;
    logic [ND*48-1:0] tod_sec;
    logic [ND*30-1:0] tod_ns;

    ptp_tod_top u_ptp_tod_top (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .cmd_we_i(cmd_we), .cmd_code_i(cmd_code), .cmd_dom_i(cmd_dom),
        .shd_sec_o(shd_sec), .shd_ns_o(shd_ns),
        .tod_sec_o(tod_sec), .tod_ns_o(tod_ns)
    );

    typedef struct {
        string       tag;
        bit          is_shd;
        int          dom;
        logic [47:0] sec;
        logic [29:0] ns;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // monitor: pops expected items and compares them with the outputs
    initial forever begin
        @(sample_ev);
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [47:0] as;
            logic [29:0] an;
            e = sb_q.pop_front();
            if (e.is_shd) begin
                as = shd_sec;
                an = shd_ns;
            end else begin
                as = tod_sec[e.dom*48 +: 48];
                an = tod_ns[e.dom*30 +: 30];
            end
            n_cmp++;
            if (as !== e.sec || an !== e.ns) begin
                n_bad++;
                $display("FAIL %s: %s got sec=%0h ns=%0h expected sec=%0h ns=%0h",
                         e.tag, e.is_shd ? "shadow" : $sformatf("domain %0d", e.dom),
                         as, an, e.sec, e.ns);
            end
        end
    end

    task automatic expect_dom(input string tag, input int d,
                              input logic [47:0] s, input logic [29:0] n);
        exp_t e;
        e.tag = tag; e.is_shd = 1'b0; e.dom = d; e.sec = s; e.ns = n;
        sb_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic expect_shd(input string tag, input logic [47:0] s, input logic [29:0] n);
        exp_t e;
        e.tag = tag; e.is_shd = 1'b1; e.dom = 0; e.sec = s; e.ns = n;
        sb_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c, input logic [1:0] d);
        cmd_code = c; cmd_dom = d; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        @(negedge clk);
    endtask

    // exactly n advancing cycles for the domains in mask
    task automatic run(input logic [2:0] mask, input int n);
        wr(4'd6, {29'd0, mask});
        repeat (n - 1) @(negedge clk);
        wr(4'd6, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_dom("R1", 0, 48'd0, 30'd0);
        expect_dom("R1", 1, 48'd0, 30'd0);
        expect_dom("R1", 2, 48'd0, 30'd0);
        expect_shd("R1", 48'd0, 30'd0);

        // R2 integer period of 8 ns on domain 0
        wr(4'd0, 32'd0);
        wr(4'd1, 32'h4000_0000);
        run(3'b001, 10);
        expect_dom("R2", 0, 48'd0, 30'd80);
        expect_dom("R3", 1, 48'd0, 30'd0);
        expect_dom("R3", 2, 48'd0, 30'd0);

        // R2 fractional period of 0.5 ns on domain 1
        wr(4'd2, 32'd0);
        wr(4'd3, 32'h0400_0000);
        run(3'b010, 7);
        expect_dom("R2", 1, 48'd0, 30'd3);
        run(3'b010, 1);
        expect_dom("R2", 1, 48'd0, 30'd4);
        expect_dom("R3", 0, 48'd0, 30'd80);

        // R11 shadow write, R8 load after idle
        wr(4'd8, 32'd0);
        wr(4'd9, 32'd5);
        wr(4'd10, 32'd999_999_990);
        expect_shd("R11", 48'd5, 30'd999_999_990);
        cmd(3'd0, 2'd0);
        cmd(3'd1, 2'd0);
        expect_dom("R8", 0, 48'd5, 30'd999_999_990);

        // R4 rollover
        run(3'b001, 1);
        expect_dom("R4", 0, 48'd5, 30'd999_999_998);
        run(3'b001, 1);
        expect_dom("R4", 0, 48'd6, 30'd6);

        // R8 load without a preceding idle is ignored
        wr(4'd9, 32'd77);
        wr(4'd10, 32'd1);
        cmd(3'd1, 2'd0);
        expect_dom("R8", 0, 48'd6, 30'd6);
        cmd(3'd0, 2'd0);
        cmd(3'd1, 2'd0);
        expect_dom("R8", 0, 48'd77, 30'd1);

        // R7 save
        cmd(3'd2, 2'd1);
        expect_shd("R7", 48'd0, 30'd4);
        cmd(3'd2, 2'd0);
        expect_shd("R7", 48'd77, 30'd1);

        // R11 upper seconds word, then load domain 2
        wr(4'd8, 32'h0000_ABCD);
        wr(4'd9, 32'h1234_5678);
        wr(4'd10, 32'd123);
        expect_shd("R11", 48'hABCD_1234_5678, 30'd123);
        cmd(3'd0, 2'd2);
        cmd(3'd1, 2'd2);
        expect_dom("R8", 2, 48'hABCD_1234_5678, 30'd123);

        // R6 no-op codes and an out-of-range domain
        cmd(3'd3, 2'd0);
        cmd(3'd5, 2'd1);
        cmd(3'd6, 2'd2);
        cmd(3'd7, 2'd0);
        cmd(3'd0, 2'd0);
        cmd(3'd2, 2'd3);
        cmd(3'd0, 2'd0);
        cmd(3'd1, 2'd3);
        cmd(3'd4, 2'd3);
        expect_dom("R6", 0, 48'd77, 30'd1);
        expect_dom("R6", 1, 48'd0, 30'd4);
        expect_dom("R6", 2, 48'hABCD_1234_5678, 30'd123);
        expect_shd("R6", 48'hABCD_1234_5678, 30'd123);

        // R9 positive delta, then with carry
        wr(4'd10, 32'd500_000_000);
        cmd(3'd4, 2'd0);
        expect_dom("R9", 0, 48'd77, 30'd500_000_001);
        cmd(3'd4, 2'd0);
        expect_dom("R9", 0, 48'd78, 30'd1);

        // R10 negative band and counting out of it
        wr(4'd10, 32'h3FFF_FFF6);
        cmd(3'd4, 2'd0);
        expect_dom("R10", 0, 48'd78, 30'h3FFF_FFF7);
        run(3'b001, 1);
        expect_dom("R10", 0, 48'd78, 30'h3FFF_FFFF);
        run(3'b001, 1);
        expect_dom("R10", 0, 48'd78, 30'd7);

        // R9 negative delta with borrow
        wr(4'd10, 32'h3FFF_FF9C);
        cmd(3'd4, 2'd0);
        expect_dom("R9", 0, 48'd77, 30'd999_999_907);

        // R5 period gate on domain 2
        wr(4'd4, 32'd0);
        wr(4'd5, 32'h4000_0000);
        run(3'b100, 2);
        expect_dom("R5", 2, 48'hABCD_1234_5678, 30'd139);
        wr(4'd7, 32'd4);
        wr(4'd5, 32'h2000_0000);
        run(3'b100, 3);
        expect_dom("R5", 2, 48'hABCD_1234_5678, 30'd163);
        wr(4'd7, 32'd0);
        run(3'b100, 3);
        expect_dom("R5", 2, 48'hABCD_1234_5678, 30'd175);
        expect_dom("R3", 0, 48'd77, 30'd999_999_907);
        expect_dom("R3", 1, 48'd0, 30'd4);

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule